// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Edge Resynchronization

This block turns a single CAN receive line into a stream of sampled bits. The line is read with a system clock that runs far faster than the bus bitrate. While idle, the block watches for the bus to leave its recessive (high) level. The first dominant (low) level it sees marks the start of a frame and fixes the timing reference. From then on the block emits one sampled bit per nominal bit time. Each bit comes with a one-cycle strobe and an index that counts up from zero.

Once collection has started, every recessive-to-dominant transition resets the timing reference. The reference is a pair: the clock count of that edge and the index of the bit not yet sampled. The next sample instant is found from that pair: the edge count, plus whole bit times for each bit passed since the edge, plus the sample-point offset. Because of this, a transmitter whose clock runs slightly fast or slow is still sampled near the intended point. Logic downstream decides when a frame is over and pulses a restart input, which sends the block back to idle.

Bit time and sample offset are fixed by parameters, in clocks. The bit time is the clock frequency divided by the nominal bitrate (default 1 Mbit/s). The sample offset is that bit time times a percentage (default 70) divided by 100, truncated.

Top module: `can_bit_sampler`

## Requirements
- R1: During reset and in the first cycle after it, `bit_valid` is 0, `bit_index` is 0 and `bit_value` is 1 (recessive).
- R2: In the idle state, no strobe is produced while `rx` stays at 1. The first 0 on `rx` starts a frame and serves as a hard synchronization for bit 0.
- R3: Let `rx` go low just before a rising clock edge k while the block is idle. The strobe for bit 0 is then high for the one cycle after edge k+OFS+2, where OFS = (CLK_HZ/BITRATE)*SAMPLE_PCT/100, truncated (70 with the defaults). `bit_value` then holds the level of `rx` at edge k+OFS. The two extra cycles come from the two-flop input synchronizer.
- R4: With no falling edge on `rx`, consecutive strobes are exactly BIT = CLK_HZ/BITRATE cycles apart (100 with the defaults). Each strobe lasts one cycle.
- R5: `bit_index` carries the index of the bit being strobed: 0, 1, 2, … in order. It changes only on a strobe or when it is cleared.
- R6: A 1-to-0 transition on `rx` while bits are being collected moves the reference. The next strobe then follows that transition with the same OFS+3 rising-edge latency as in R3, whatever time had already passed in the current bit.
- R7: A `restart` pulse returns the block to idle: `bit_valid` is 0 and `bit_index` is 0 in the next cycle. No strobe follows while `rx` stays at 1. The next frame starts again at index 0, with the latency given in R3.
- R8: Frames with bit stuffing (an opposite bit after five equal bits) are sampled with every value and index correct. This holds at the nominal rate and at transmitter bit times 1 % and 2 % shorter or longer than nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Asynchronous CAN receive line, 1 = recessive |
| restart | input | 1 | Synchronous request to return to idle and clear the index |
| bit_valid | output | 1 | One-cycle strobe for each sampled bit |
| bit_value | output | 1 | Level of the line at the sample point |
| bit_index | output | IDX_W | Index of the strobed bit within the frame |

## Verification
The assertions assume the following about the inputs:
- BIT is at least 2 and OFS is at least 1, so two strobes can never fall in adjacent cycles.
- `restart` is synchronous to `clk`.
- `rx` is settled well away from the rising edge.

The bench keeps to these assumptions in the following ways:
- It changes `rx` only on falling clock edges.
- It holds each bus bit for 98 to 102 clocks.
- It inserts stuff bits, so a falling edge reaches the sampler at least every eleven bits and the drift between resynchronizations stays well inside one bit.
- It pulses `restart` only while the line is recessive, after the last bit of a frame has been strobed.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
  typedef enum logic {
    BS_IDLE = 1'b0,
    BS_RUN  = 1'b1
  } bs_state_e;
endpackage

// File: rtl/can_bs_sync.sv
module can_bs_sync (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_sync,
  output logic rx_fall
);
  logic meta_q;
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_sync = sync_q;
  assign rx_fall = prev_q & ~sync_q;

  logic [1:0] arm_q;
  always_ff @(posedge clk) begin
    if (rst) arm_q <= 2'b00;
    else     arm_q <= {arm_q[0], 1'b1};
  end

  // R3: synchronized level trails the pin by exactly two clocks
  p_sync_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (arm_q == 2'b11) |-> (rx_sync == $past(rx_in, 2)));
endmodule

// File: rtl/can_bs_timer.sv
module can_bs_timer #(
  parameter int BIT_CLKS   = 100,
  parameter int SAMPLE_OFS = 70,
  parameter int SPAN_MAX   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic ref_now,
  output logic hit
);
  localparam int EL_MAX = SPAN_MAX * BIT_CLKS + SAMPLE_OFS + 2;
  localparam int EL_W   = $clog2(EL_MAX + 1);
  localparam int SPAN_W = $clog2(SPAN_MAX + 1);
  localparam logic [EL_W-1:0]   BIT_L  = EL_W'(BIT_CLKS);
  localparam logic [EL_W-1:0]   OFS_L  = EL_W'(SAMPLE_OFS);
  localparam logic [SPAN_W-1:0] SPAN_L = SPAN_W'(SPAN_MAX);

  // elapsed: clocks since the reference edge (0 in the edge cycle)
  // span:    bit index now awaited minus bit index at the edge
  logic [EL_W-1:0]   elapsed_q;
  logic [SPAN_W-1:0] span_q;
  logic [EL_W-1:0]   target;

  always_comb begin
    target = EL_W'(span_q) * BIT_L + OFS_L;
    hit    = active && (elapsed_q == target);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      elapsed_q <= '0;
      span_q    <= '0;
    end else if (ref_now) begin
      elapsed_q <= EL_W'(1);
      span_q    <= hit ? SPAN_W'(1) : '0;
    end else if (hit) begin
      if (span_q == SPAN_L) begin
        elapsed_q <= OFS_L + EL_W'(1);
        span_q    <= SPAN_W'(1);
      end else begin
        elapsed_q <= elapsed_q + EL_W'(1);
        span_q    <= span_q + SPAN_W'(1);
      end
    end else if (active) begin
      elapsed_q <= elapsed_q + EL_W'(1);
    end
  end

  // R4: sample instants never fall in adjacent cycles
  p_spaced_hits_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int BITRATE    = 1_000_000,
  parameter int SAMPLE_PCT = 70,
  parameter int SPAN_MAX   = 16,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx,
  input  logic             restart,
  output logic             bit_valid,
  output logic             bit_value,
  output logic [IDX_W-1:0] bit_index
);
  import can_bs_pkg::*;

  localparam int BIT_CLKS   = CLK_HZ / BITRATE;
  localparam int SAMPLE_OFS = (BIT_CLKS * SAMPLE_PCT) / 100;

  logic      rx_sync;
  logic      rx_fall;
  logic      hit;
  logic      ref_now;
  logic      running;
  bs_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  can_bs_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .rx_in   (rx),
    .rx_sync (rx_sync),
    .rx_fall (rx_fall)
  );

  assign running = (state_q == BS_RUN);
  assign ref_now = !restart &&
                   ((!running && !rx_sync) || (running && rx_fall));

  can_bs_timer #(
    .BIT_CLKS   (BIT_CLKS),
    .SAMPLE_OFS (SAMPLE_OFS),
    .SPAN_MAX   (SPAN_MAX)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (restart),
    .active  (running),
    .ref_now (ref_now),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state_q   <= BS_IDLE;
      idx_q     <= '0;
      bit_valid <= 1'b0;
      bit_value <= 1'b1;
      bit_index <= '0;
    end else begin
      bit_valid <= hit;
      if (hit) begin
        bit_value <= rx_sync;
        bit_index <= idx_q;
        idx_q     <= idx_q + IDX_W'(1);
      end
      if (!running && !rx_sync) state_q <= BS_RUN;
    end
  end

  // R2: nothing is strobed out of the idle state
  p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_IDLE) |=> !bit_valid);

  // R7: restart clears the strobe and the index, and returns to idle
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!bit_valid && bit_index == '0 && state_q == BS_IDLE));

  // R5: the index moves only with a strobe or when cleared
  p_index_moves_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_index) |-> (bit_valid || bit_index == '0));
endmodule

// File: tb/can_bit_sampler_tb_top.sv
module can_bit_sampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT  = 100;
  localparam int OFS  = 70;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] period;
    logic [31:0] pat;
    logic [31:0] nbits;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'd100, 32'h0F0F_33CC, 32'd32},
    '{32'd99,  32'h7FFF_0001, 32'd32},
    '{32'd101, 32'h0000_FFFF, 32'd32},
    '{32'd98,  32'h5A5A_A5A5, 32'd32},
    '{32'd102, 32'h0ACE_1234, 32'd32},
    '{32'd100, 32'h3C00_7E81, 32'd20}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic restart = 1'b0;
  logic bit_valid;
  logic bit_value;
  logic [7:0] bit_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_sampler dut_i (
    .clk       (clk),
    .rst       (rst),
    .rx        (rx),
    .restart   (restart),
    .bit_valid (bit_valid),
    .bit_value (bit_value),
    .bit_index (bit_index)
  );

  // strobe monitor: posedge counter, strobes recorded at falling edges
  int pcount = 0;
  int total = 0;
  bit cap_val [64];
  int cap_idx [64];
  int cap_cyc [64];

  always @(posedge clk) pcount = pcount + 1;

  always @(negedge clk) begin
    if (bit_valid) begin
      cap_val[total % 64] = bit_value;
      cap_idx[total % 64] = int'(bit_index);
      cap_cyc[total % 64] = pcount;
      total = total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_restart();
    rx = 1'b1;
    repeat (4) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  bit raw [64];
  int raw_n;

  task automatic build_raw(input logic [31:0] pat, input int nbits);
    int run = 0;
    bit last = 1'b1;
    raw_n = 0;
    for (int i = 0; i < nbits; i++) begin
      bit b = pat[31 - i];
      raw[raw_n] = b;
      raw_n++;
      if (raw_n > 1 && b == last) run++; else run = 1;
      last = b;
      if (run == 5) begin
        raw[raw_n] = ~b;
        raw_n++;
        last = ~b;
        run = 1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int p0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(bit_valid == 1'b0 && bit_index == 8'd0, "R1 in reset", int'(bit_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bit_valid == 1'b0 && bit_index == 8'd0 && bit_value == 1'b1,
        "R1 after reset", int'({bit_valid, bit_value}), 1);

    // R2: idle recessive line yields no strobes
    base = total;
    repeat (500) @(negedge clk);
    chk(total == base, "R2 idle silent", total - base, 0);

    // R3 / R4 / R5: start of frame latency, spacing, index
    base = total;
    rx = 1'b0;
    p0 = pcount;
    repeat (OFS + 2 * BIT + 20) @(negedge clk);
    chk(total - base >= 3, "R3 strobes seen", total - base, 3);
    chk(cap_cyc[base % 64] == p0 + OFS + 3, "R3 first strobe cycle",
        cap_cyc[base % 64] - p0, OFS + 3);
    chk(cap_val[base % 64] == 1'b0 && cap_idx[base % 64] == 0, "R3 first bit",
        cap_idx[base % 64], 0);
    chk(cap_cyc[(base + 1) % 64] - cap_cyc[base % 64] == BIT, "R4 spacing",
        cap_cyc[(base + 1) % 64] - cap_cyc[base % 64], BIT);
    chk(cap_cyc[(base + 2) % 64] - cap_cyc[(base + 1) % 64] == BIT, "R4 spacing 2",
        cap_cyc[(base + 2) % 64] - cap_cyc[(base + 1) % 64], BIT);
    chk(cap_idx[(base + 1) % 64] == 1 && cap_idx[(base + 2) % 64] == 2, "R5 index",
        cap_idx[(base + 2) % 64], 2);
    do_restart();

    // R4: one-cycle strobe width
    rx = 1'b0;
    repeat (OFS + 3) @(negedge clk);
    chk(bit_valid == 1'b1, "R4 strobe high", int'(bit_valid), 1);
    @(negedge clk);
    chk(bit_valid == 1'b0, "R4 strobe one cycle", int'(bit_valid), 0);
    do_restart();

    // R6: late falling edge moves the sample point
    base = total;
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (BIT + 30) @(negedge clk);
    rx = 1'b0;
    p0 = pcount;
    repeat (OFS + 10) @(negedge clk);
    chk(total - base == 3, "R6 strobe count", total - base, 3);
    chk(cap_val[(base + 1) % 64] == 1'b1, "R6 bit 1 value", int'(cap_val[(base + 1) % 64]), 1);
    chk(cap_cyc[(base + 2) % 64] == p0 + OFS + 3, "R6 resync cycle",
        cap_cyc[(base + 2) % 64] - p0, OFS + 3);
    chk(cap_idx[(base + 2) % 64] == 2 && cap_val[(base + 2) % 64] == 1'b0, "R6 bit 2",
        cap_idx[(base + 2) % 64], 2);

    // R7: restart clears and waits for a new frame
    rx = 1'b1;
    repeat (4) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(bit_valid == 1'b0 && bit_index == 8'd0, "R7 cleared", int'(bit_index), 0);
    base = total;
    repeat (400) @(negedge clk);
    chk(total == base, "R7 idle after restart", total - base, 0);
    rx = 1'b0;
    p0 = pcount;
    repeat (OFS + 10) @(negedge clk);
    chk(total - base == 1 && cap_idx[base % 64] == 0, "R7 index from zero",
        cap_idx[base % 64], 0);
    chk(cap_cyc[base % 64] == p0 + OFS + 3, "R7 new frame latency",
        cap_cyc[base % 64] - p0, OFS + 3);
    do_restart();

    // R8: stuffed frames at nominal and skewed rates
    for (int v = 0; v < NVEC; v++) begin
      int bad = 0;
      build_raw(VECS[v].pat, int'(VECS[v].nbits));
      repeat (50) @(negedge clk);
      base = total;
      for (int i = 0; i < raw_n; i++) begin
        rx = raw[i];
        repeat (int'(VECS[v].period)) @(negedge clk);
      end
      do_restart();
      chk(total - base == raw_n, "R8 bit count", total - base, raw_n);
      for (int i = 0; i < raw_n && i < total - base; i++) begin
        if (cap_val[(base + i) % 64] != raw[i] || cap_idx[(base + i) % 64] != i) bad++;
      end
      chk(bad == 0, "R8 values and indices", bad, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule